// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block holds the per-interrupt CPU-target bytes of an interrupt distributor and exposes them on a small 32-bit register bus. Each interrupt owns one byte. Bit c of that byte marks CPU interface c as a destination for the interrupt. Four interrupts share one bus word.

The bank decodes a fixed window of the distributor's address space. Bits for CPUs that are not implemented are dropped on every write, in every byte lane. Addresses for interrupts that do not exist read as zero and ignore writes. The first 32 interrupts are private to each CPU, so their bytes are fixed and read-only. Every target byte is also driven on a flat output vector, where routing logic elsewhere picks it up.

Top module: `irq_target_bank`

## Requirements
- R1: The window covers byte offsets 0x800 to 0xBFF. Word k of the window (offset 0x800 + 4k) holds interrupts 4k to 4k+3. Interrupt n sits in bits [8*(n mod 4)+7 : 8*(n mod 4)] of its word. The low two address bits are ignored.
- R2: A write to a field of interrupt 32 or above stores the written byte ANDed with the CPU mask, where bit c is set for c < NUM_CPUS. This holds in every byte lane.
- R3: Writing 0xFFFFFFFF to an implemented shared-interrupt word reads back as the CPU mask repeated in all four bytes. Writing 0x0103020F reads back as that pattern ANDed with the repeated mask.
- R4: Byte enable i (be[i]) gates lane i. A write changes only the lanes whose enable is set and leaves the other lanes unchanged.
- R5: Fields of interrupts numbered NUM_IRQS or above read as zero, and writes to them change nothing.
- R6: Fields of interrupts 0 to 31 are read-only. Each reads as 0x01 (CPU 0 only) and drives 0x01 on the target output.
- R7: After reset, every field of interrupts 32 and above is zero.
- R8: Read data is registered. It reflects the addressed word one clock after rd_en is high and holds otherwise. A read and a write in the same cycle return the value from before the write.
- R9: Offsets outside the window read as zero, and writes to them change no field.
- R10: Byte n of the targets output always equals the current field of interrupt n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte offset from the distributor base |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane enables for writes |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| targets | output | 8*NUM_IRQS | Target byte of each interrupt, interrupt n at bits [8n+7:8n] |

## Verification
A read and a write can hit the bank on the same clock edge, and the read must see the word as it was before the edge. The bench drives both strobes in one cycle to the same shared-interrupt word. It expects the old contents on rdata, then reads the word again and expects the newly written masked value. The bench also sweeps every word of the window and both out-of-window neighbours. It checks all-ones, the 0x0103020F pattern, single-byte writes and writes beyond the interrupt limit, comparing against a byte model kept in the bench.

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 96,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [3:0]            be,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [31:0]           rdata,
  output logic [8*NUM_IRQS-1:0] targets
);

  localparam int NUM_PRIV  = 32;
  localparam int NUM_SPI   = NUM_IRQS - NUM_PRIV;
  localparam int SPI_W     = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam int WIN_BASE  = 'h800;
  localparam int WIN_BYTES = 1024;
  localparam int WIDX_W    = $clog2(WIN_BYTES / 4);
  localparam logic [7:0] CPU_MASK = 8'((1 << NUM_CPUS) - 1);
  localparam logic [7:0] PRIV_VAL = 8'h01;

  logic [ADDR_W-1:0] offs;
  logic              in_win;
  logic [WIDX_W-1:0] word_idx;
  logic [7:0]        spi_q [NUM_SPI];
  logic [31:0]       rd_word;

  assign offs     = addr - ADDR_W'(WIN_BASE);
  assign in_win   = (addr >= ADDR_W'(WIN_BASE)) && (addr < ADDR_W'(WIN_BASE + WIN_BYTES));
  assign word_idx = offs[WIDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SPI; i++) spi_q[i] <= 8'h00;
    end else if (wr_en && in_win) begin
      for (int i = 0; i < NUM_SPI; i++) begin
        if (word_idx == WIDX_W'((i + NUM_PRIV) / 4) && be[2'(i % 4)])
          spi_q[i] <= wdata[8*(i % 4) +: 8] & CPU_MASK;
      end
    end
  end

  always_comb begin
    rd_word = 32'h0;
    for (int l = 0; l < 4; l++) begin
      int irq;
      irq = int'(word_idx) * 4 + l;
      if (!in_win)               rd_word[8*l +: 8] = 8'h00;
      else if (irq < NUM_PRIV)   rd_word[8*l +: 8] = PRIV_VAL;
      else if (irq < NUM_IRQS)   rd_word[8*l +: 8] = spi_q[SPI_W'(irq - NUM_PRIV)];
      else                       rd_word[8*l +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 32'h0;
    else if (rd_en) rdata <= rd_word;
  end

  for (genvar g = 0; g < NUM_IRQS; g++) begin : g_out
    if (g < NUM_PRIV) begin : g_priv
      assign targets[8*g +: 8] = PRIV_VAL;
    end else begin : g_spi
      assign targets[8*g +: 8] = spi_q[g - NUM_PRIV];
    end
  end

  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((targets & {NUM_IRQS{~CPU_MASK}}) == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(targets));

  assert_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_win) |=> $stable(targets));

  assert_outside_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_win) |=> (rdata == 32'h0));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (targets[7:0] == PRIV_VAL) && (targets[8*NUM_PRIV-1 -: 8] == PRIV_VAL));

endmodule

// File: tb/tb_irq_target_bank.sv
module tb_irq_target_bank;
  localparam int NCPU  = 3;
  localparam int NIRQ  = 44;
  localparam int AW    = 12;
  localparam logic [7:0] MASK = 8'h07;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] be = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic [8*NIRQ-1:0] targets;

  int checks = 0, errors = 0;
  logic [7:0] model [NIRQ];

  irq_target_bank #(.NUM_CPUS(NCPU), .NUM_IRQS(NIRQ), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .targets(targets));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_rd(input int a);
    logic [31:0] w = 0;
    if (a < 'h800 || a >= 'hC00) return 0;
    for (int l = 0; l < 4; l++) begin
      int n = ((a - 'h800) / 4) * 4 + l;
      if (n < NIRQ) w[8*l +: 8] = model[n];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = AW'(a); wdata = d; be = b; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a >= 'h800 && a < 'hC00)
      for (int l = 0; l < 4; l++) begin
        int n = ((a - 'h800) / 4) * 4 + l;
        if (b[l] && n >= 32 && n < NIRQ) model[n] = d[8*l +: 8] & MASK;
      end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic chk_targets(input string req);
    for (int n = 0; n < NIRQ; n++) chk(req, 32'(targets[8*n +: 8]), 32'(model[n]));
  endtask

  task automatic sweep(input string req);
    logic [31:0] d;
    for (int w = 0; w < 256; w++) begin
      rd('h800 + 4 * w, d);
      chk(req, d, exp_rd('h800 + 4 * w));
    end
  endtask

  initial begin
    logic [31:0] d;
    for (int n = 0; n < NIRQ; n++) model[n] = (n < 32) ? 8'h01 : 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset rdata", rdata, 0);
    rst_n = 1;
    chk_targets("R7/R6/R10 reset targets");
    sweep("R7/R6/R1 reset sweep");

    for (int w = 8; w < 11; w++) begin
      wr('h800 + 4 * w, 32'hFFFFFFFF, 4'hF);
      rd('h800 + 4 * w, d);
      chk("R3 all ones", d, 32'h07070707);
      wr('h800 + 4 * w + 3, 32'h0103020F, 4'hF);
      rd('h800 + 4 * w + 1, d);
      chk("R3/R2 pattern", d, 32'h01030207);
    end
    chk_targets("R10 after patterns");

    for (int l = 0; l < 4; l++) begin
      wr('h820, 32'hA5A5A5A5 ^ (32'h11 << (8 * l)), 4'(1 << l));
      rd('h820, d);
      chk("R4 byte write", d, exp_rd('h820));
    end
    for (int v = 0; v < 256; v += 17) begin
      wr('h824, {4{8'(v)}}, 4'b0100);
      rd('h824, d);
      chk("R2 lane2 mask", d, exp_rd('h824));
    end

    for (int w = 0; w < 8; w++) wr('h800 + 4 * w, 32'h0, 4'hF);
    for (int w = 11; w < 256; w++) wr('h800 + 4 * w, 32'hFFFFFFFF, 4'hF);
    sweep("R5/R6 read-only and beyond limit");
    chk_targets("R5/R6 targets unchanged");

    wr('h7FC, 32'hFFFFFFFF, 4'hF);
    wr('hC00, 32'hFFFFFFFF, 4'hF);
    wr('h000, 32'hFFFFFFFF, 4'hF);
    rd('h7FC, d); chk("R9 below window", d, 0);
    rd('hC00, d); chk("R9 above window", d, 0);
    chk_targets("R9 targets unchanged");

    wr('h828, 32'h02020202, 4'hF);
    @(negedge clk);
    addr = AW'('h828); wdata = 32'h05050505; be = 4'hF; wr_en = 1; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R8 read during write old value", rdata, 32'h02020202);
    for (int n = 40; n < 44; n++) model[n] = 8'h05;
    @(negedge clk);
    chk("R8 rdata holds", rdata, 32'h02020202);
    rd('h828, d);
    chk("R8 new value", d, 32'h05050505);
    chk_targets("R10 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule